// File: doc/BRIEF.md
# Storage Host Interrupt Status Controller

This block is the interrupt register set for a storage host. It holds a raw event word, a mask word and a control word that carries the global interrupt enable. It also holds a separate status word for the DMA engine. From these it drives one level-sensitive interrupt line. Other logic raises events by pulsing bits of a set vector, and software acknowledges them by writing ones. A card-detect level input produces insert and remove events and keeps a card-present flag.

Software reaches the block through a plain 32-bit register port. The port has a write strobe, a word address and a combinational read data bus. The word addresses are: 0 control, 1 mask, 2 masked status, 3 raw status, 4 card/data status, 5 DMA status.

Top module: `sirq_ctrl`

## Requirements
- R1: `irq_o` is high only when control bit 4 was set and at least one bit of (raw status AND mask) was set. With control bit 4 clear, `irq_o` is low whatever the raw status and the mask hold.
- R2: A read of address 2 returns raw status AND mask. A write to address 2 or to address 3 clears every raw status bit written as 1, and the mask does not limit which bits are cleared. A read of address 1 returns the mask last written.
- R3: When an event pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R4: A write to address 0 stores the value, except that bits 2:0 always read back as 0.
- R5: When `card_in` rises, raw bit 30 is set, raw bit 31 is cleared and status bit 8 is set. When it falls, raw bit 31 is set, raw bit 30 is cleared and status bit 8 is cleared. Raw bits 30 and 31 are never both set. Pulses on `evt_set` cannot set bits 30 or 31.
- R6: In the DMA status word (address 5), a write clears only the bits within 9:0 that are written as 1. Bits 10 and up keep their value. Pulses on `dma_set` set bits in this word.
- R7: After reset, control reads 0x300, status reads 0x100 plus its data-ready indication, and raw status, mask, DMA status and `irq_o` are all 0.
- R8: Status (address 4) shows bit 2 when `data_ready` is low and bit 17 when it is high. Writing a 1 to bit 8 clears the card-present flag.
- R9: `irq_o` is registered. It reflects the status, mask and enable one clock after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_set | input | 32 | One-cycle event pulses into the raw status |
| dma_set | input | DMA_W | One-cycle event pulses into the DMA status |
| card_in | input | 1 | Card-detect level, 1 = card present |
| data_ready | input | 1 | Card data is available |
| irq_o | output | 1 | Level interrupt output |

## Verification
The assertions take for granted that `card_in` is already synchronous to `clk`, so that at most one insert or remove edge occurs per cycle. They also assume the reset value of the card sampler matches a card that is present at power-up. The bench changes `card_in` only on falling clock edges and holds it for several cycles between transitions. Event pulses last exactly one cycle, and the bench never lets `evt_set` and `card_in` touch the same bit in the same cycle.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
   localparam int REG_W = 32;
   localparam int AW    = 3;

   localparam logic [AW-1:0] A_CTRL  = 3'd0;
   localparam logic [AW-1:0] A_MASK  = 3'd1;
   localparam logic [AW-1:0] A_MSTAT = 3'd2;
   localparam logic [AW-1:0] A_RSTAT = 3'd3;
   localparam logic [AW-1:0] A_CSTAT = 3'd4;
   localparam logic [AW-1:0] A_DSTAT = 3'd5;

   localparam int BIT_IEN   = 4;
   localparam int BIT_INS   = 30;
   localparam int BIT_REM   = 31;
   localparam int BIT_PRES  = 8;
   localparam int BIT_EMPTY = 2;
   localparam int BIT_LVL   = 17;

   localparam logic [REG_W-1:0] CTRL_RST     = 32'h0000_0300;
   localparam logic [REG_W-1:0] CTRL_SELFCLR = 32'h0000_0007;
   localparam logic [REG_W-1:0] CARD_BITS    = (32'h1 << BIT_INS) | (32'h1 << BIT_REM);
endpackage

// File: rtl/sirq_sticky.sv
module sirq_sticky #(
   parameter int           W        = 32,
   parameter logic [W-1:0] CLR_MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] hw_clr_i,
   input  logic         sw_wr_i,
   input  logic [W-1:0] sw_data_i,
   output logic [W-1:0] q_o
);
   localparam logic [W-1:0] KEEP = ~CLR_MASK;

   logic [W-1:0] sw_clr;
   logic [W-1:0] q_n;

   always_comb begin
      sw_clr = sw_wr_i ? (sw_data_i & CLR_MASK) : '0;
      q_n    = (q_o & ~sw_clr & ~hw_clr_i) | set_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= q_n;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i))); // R3

   AST_KEEP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr_i && hw_clr_i == '0) |=> ((~q_o & $past(q_o) & KEEP) == '0)); // R6
endmodule

// File: rtl/sirq_card.sv
module sirq_card (
   input  logic clk,
   input  logic rst_n,
   input  logic card_i,
   input  logic pres_clr_i,
   output logic ins_o,
   output logic rem_o,
   output logic present_o
);
   logic card_q;

   assign ins_o = card_i & ~card_q;
   assign rem_o = ~card_i & card_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         card_q    <= 1'b1;
         present_o <= 1'b1;
      end else begin
         card_q <= card_i;
         if (ins_o)           present_o <= 1'b1;
         else if (rem_o)      present_o <= 1'b0;
         else if (pres_clr_i) present_o <= 1'b0;
      end
   end

   AST_PRES_ON_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_i) |=> present_o); // R5

   AST_PRES_ON_REMOVE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(card_i) |=> !present_o); // R5
endmodule

// File: rtl/sirq_line.sv
module sirq_line #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic [W-1:0] raw_i,
   input  logic [W-1:0] mask_i,
   output logic         irq_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= en_i & (|(raw_i & mask_i));
   end

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(en_i)); // R1

   AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(|(raw_i & mask_i))); // R9
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
   import sirq_pkg::*;
#(
   parameter int DMA_W     = 16,
   parameter int DMA_CLR_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [AW-1:0]    reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic [REG_W-1:0] evt_set,
   input  logic [DMA_W-1:0] dma_set,
   input  logic             card_in,
   input  logic             data_ready,
   output logic             irq_o
);
   localparam logic [DMA_W-1:0] DMA_CLR_MASK = DMA_W'((64'h1 << DMA_CLR_W) - 1);

   generate
      if (DMA_CLR_W < 1 || DMA_CLR_W > DMA_W) begin : g_bad_clr
         $error("DMA_CLR_W must lie in 1..DMA_W");
      end
      if (DMA_W > REG_W) begin : g_bad_dma
         $error("DMA_W must not exceed the register width");
      end
   endgenerate

   logic [REG_W-1:0] ctrl_q, mask_q, raw_q;
   logic [DMA_W-1:0] dma_q;
   logic [REG_W-1:0] dma_rd;
   logic             ins, rem, present;
   logic             wr_ctrl, wr_mask, wr_raw, wr_dma, wr_cstat;
   logic [REG_W-1:0] raw_set, raw_hw_clr;

   assign wr_ctrl  = reg_wr && reg_addr == A_CTRL;
   assign wr_mask  = reg_wr && reg_addr == A_MASK;
   assign wr_raw   = reg_wr && (reg_addr == A_MSTAT || reg_addr == A_RSTAT);
   assign wr_dma   = reg_wr && reg_addr == A_DSTAT;
   assign wr_cstat = reg_wr && reg_addr == A_CSTAT;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         mask_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= reg_wdata & ~CTRL_SELFCLR;
         if (wr_mask) mask_q <= reg_wdata;
      end
   end

   sirq_card u_card (
      .clk        (clk),
      .rst_n      (rst_n),
      .card_i     (card_in),
      .pres_clr_i (wr_cstat && reg_wdata[BIT_PRES]),
      .ins_o      (ins),
      .rem_o      (rem),
      .present_o  (present)
   );

   always_comb begin
      raw_set    = evt_set & ~CARD_BITS;
      raw_hw_clr = '0;
      if (ins) begin
         raw_set[BIT_INS]    = 1'b1;
         raw_hw_clr[BIT_REM] = 1'b1;
      end
      if (rem) begin
         raw_set[BIT_REM]    = 1'b1;
         raw_hw_clr[BIT_INS] = 1'b1;
      end
   end

   sirq_sticky #(.W(REG_W), .CLR_MASK('1)) u_raw (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (raw_set),
      .hw_clr_i  (raw_hw_clr),
      .sw_wr_i   (wr_raw),
      .sw_data_i (reg_wdata),
      .q_o       (raw_q)
   );

   sirq_sticky #(.W(DMA_W), .CLR_MASK(DMA_CLR_MASK)) u_dma (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (dma_set),
      .hw_clr_i  ('0),
      .sw_wr_i   (wr_dma),
      .sw_data_i (reg_wdata[DMA_W-1:0]),
      .q_o       (dma_q)
   );

   generate
      if (DMA_W < REG_W) begin : g_dma_ext
         assign dma_rd = {{(REG_W-DMA_W){1'b0}}, dma_q};
      end else begin : g_dma_full
         assign dma_rd = dma_q;
      end
   endgenerate

   sirq_line #(.W(REG_W)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (ctrl_q[BIT_IEN]),
      .raw_i  (raw_q),
      .mask_i (mask_q),
      .irq_o  (irq_o)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL:  reg_rdata = ctrl_q;
         A_MASK:  reg_rdata = mask_q;
         A_MSTAT: reg_rdata = raw_q & mask_q;
         A_RSTAT: reg_rdata = raw_q;
         A_CSTAT: begin
            reg_rdata[BIT_PRES] = present;
            if (data_ready) reg_rdata[BIT_LVL]   = 1'b1;
            else            reg_rdata[BIT_EMPTY] = 1'b1;
         end
         A_DSTAT: reg_rdata = dma_rd;
         default: reg_rdata = '0;
      endcase
   end

   AST_INS_REM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(raw_q[BIT_INS] && raw_q[BIT_REM])); // R5

   AST_CTRL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_ctrl) |-> (ctrl_q[2:0] == 3'b000)); // R4
endmodule

// File: tb/sim_sirq_ctrl.sv
module sim_sirq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] evt_set = '0;
   logic [15:0] dma_set = '0;
   logic        card_in = 1'b1;
   logic        data_ready = 1'b0;
   logic        irq_o;

   always #5 clk = ~clk;

   sirq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
      .dma_set(dma_set), .card_in(card_in), .data_ready(data_ready), .irq_o(irq_o)
   );

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   event  go;
   int    checks = 0;
   int    errors = 0;
   bit    done = 0;

   initial begin : monitor
      forever begin
         @(go);
         #1;
         if (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_irq ? {31'b0, irq_o} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic chk_reg(input logic [2:0] a, input logic [31:0] e, input string t);
      item_t it;
      reg_addr = a;
      it.is_irq = 0; it.exp = e; it.tag = t;
      q.push_back(it);
      -> go;
      #2;
   endtask

   task automatic chk_irq(input logic e, input string t);
      item_t it;
      it.is_irq = 1; it.exp = {31'b0, e}; it.tag = t;
      q.push_back(it);
      -> go;
      #2;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      #200000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_reg(3'd0, 32'h300, "R7 control reset");
      chk_reg(3'd4, 32'h104, "R7 status reset");
      chk_reg(3'd3, 32'h0,   "R7 raw reset");
      chk_reg(3'd5, 32'h0,   "R7 dma reset");
      chk_irq(1'b0, "R7 irq reset");

      data_ready = 1'b1;
      chk_reg(3'd4, 32'h20100, "R8 level bit when ready");

      @(negedge clk); evt_set = 32'h4;
      @(negedge clk); evt_set = '0;
      chk_reg(3'd3, 32'h4, "R2 raw after event");
      chk_reg(3'd2, 32'h0, "R2 masked view with mask 0");

      wr(3'd1, 32'h4);
      chk_reg(3'd1, 32'h4, "R2 mask readback");
      chk_reg(3'd2, 32'h4, "R2 masked view with mask set");
      idle(1);
      chk_irq(1'b0, "R1 no irq without enable");

      wr(3'd0, 32'h317);
      chk_reg(3'd0, 32'h310, "R4 self-clearing bits");
      chk_irq(1'b0, "R9 irq lags enable by one clock");
      idle(1);
      chk_irq(1'b1, "R1 irq with enable");

      wr(3'd2, 32'h4);
      chk_reg(3'd3, 32'h0, "R2 clear via masked address");
      chk_irq(1'b1, "R9 irq still high one clock");
      idle(1);
      chk_irq(1'b0, "R9 irq drops after clear");

      @(negedge clk);
      evt_set = 32'h8; reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h8;
      @(negedge clk);
      evt_set = '0; reg_wr = 1'b0;
      chk_reg(3'd3, 32'h8, "R3 set wins over clear");
      wr(3'd3, 32'h8);
      chk_reg(3'd3, 32'h0, "R2 clear via raw address");

      @(negedge clk); evt_set = 32'hC000_0001;
      @(negedge clk); evt_set = '0;
      chk_reg(3'd3, 32'h1, "R5 events cannot set card bits");
      wr(3'd3, 32'h1);

      card_in = 1'b0;
      idle(2);
      chk_reg(3'd3, 32'h8000_0000, "R5 remove event");
      chk_reg(3'd4, 32'h20000, "R5 present cleared on removal");
      card_in = 1'b1;
      idle(2);
      chk_reg(3'd3, 32'h4000_0000, "R5 insert event clears remove");
      chk_reg(3'd4, 32'h20100, "R5 present set on insert");

      wr(3'd4, 32'h100);
      chk_reg(3'd4, 32'h20000, "R8 present cleared by write");
      data_ready = 1'b0;
      chk_reg(3'd4, 32'h4, "R8 empty bit when not ready");

      wr(3'd1, 32'h4000_0000);
      idle(1);
      chk_irq(1'b1, "R1 irq from insert event");
      wr(3'd0, 32'h300);
      idle(1);
      chk_irq(1'b0, "R1 irq gated off by enable");
      chk_reg(3'd2, 32'h4000_0000, "R2 masked view independent of enable");

      @(negedge clk); dma_set = 16'h0C03;
      @(negedge clk); dma_set = '0;
      chk_reg(3'd5, 32'hC03, "R6 dma events set");
      wr(3'd5, 32'hFFFF_FFFF);
      chk_reg(3'd5, 32'hC00, "R6 only low field cleared");

      wr(3'd0, 32'hFFFF_FFFF);
      chk_reg(3'd0, 32'hFFFF_FFF8, "R4 all other bits stored");

      idle(2);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule